// File: doc/BRIEF.md
# Four-Channel DMA Register File

This block holds the host-visible register state of a four-channel DMA controller that sits on an 8-bit I/O bus with a 4-bit port offset. Each channel keeps a 16-bit start address and a 16-bit transfer count, each in two copies. The base copy is what the host last wrote. The current copy is the working value. Both 16-bit values pass through a single byte-wide port per channel. One shared byte-select toggle decides whether an access reaches the low byte or the high byte. The upper eight offsets hold the control ports: command and status, single-channel mask, mode, byte-select reset, master clear, unmask-all and mask-load.

The block does not arbitrate and does not move data. A transfer engine outside the block pulses a strobe together with a channel number, and the block steps that channel's current count down by one. When the count runs out, the block records a terminal-count flag. If the channel's mode asks for it, the block also restores the working values from the base copies. The host programs a channel by writing the low byte and then the high byte of its address and count. It sets the mode, unmasks the channel, and later polls the status port to see which channels have finished.

Top module: `dma_regfile`

## Requirements
- R1: After reset, all four mask bits are 1, the byte-select toggle points at the low byte, the terminal-count flags, command byte and cascade outputs are 0, and all address and count registers read 0x00.
- R2: Offset 2n (n = 0..3) is channel n's address port and offset 2n+1 its count port. Successive accesses to the same port reach the low byte and then the high byte. The byte-select toggle flips after every read or write to any of offsets 0 to 7. Reads return the current copy.
- R3: Any write to offset 12 returns the byte-select toggle to the low byte, whatever the data.
- R4: A write to offset 10 picks the channel with data bits [1:0] and sets that channel's mask bit to data bit 2. The other mask bits are unchanged.
- R5: A write to offset 14 clears all four mask bits. A write to offset 15 loads mask bit i from data bit i, for i = 0..3.
- R6: A write to offset 11 picks the channel with data bits [1:0] and stores its mode. Data bit 4 enables auto-reload. Data bits [7:6] = 11 select cascade, which shows on that channel's bit of cascade_o.
- R7: A transfer strobe on an unmasked channel lowers its current count by one. A strobe on a masked channel changes no count and sets no flag.
- R8: A strobe that finds the current count at 0x0000 sets that channel's terminal-count flag. Without auto-reload the count becomes 0xFFFF. With auto-reload the current address and count are reloaded from the base copies.
- R9: A read at offset 8 returns the terminal-count flags in bits [3:0], with bits [7:4] zero, and clears them. A flag set by a strobe in the same cycle as that read survives.
- R10: A write to offset 8 loads the command byte. A write to offset 13 sets all mask bits, returns the byte-select toggle to the low byte, and clears the flags and the command byte. Address, count and mode registers are kept.
- R11: A read at offset 13 returns 0x00, because this block holds no transfer data.
- R12: A host write to an address or count byte loads the same byte of both the base copy and the current copy, so an auto-reload restores the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Port offset of the host access |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data for the offset on io_addr (combinational) |
| xfer_strobe | input | 1 | One transfer completed on xfer_chan |
| xfer_chan | input | 2 | Channel of the transfer strobe |
| mask_o | output | 4 | Per-channel mask bits |
| cascade_o | output | 4 | Per-channel cascade mode |
| cmd_o | output | 8 | Command byte |

## Verification
The bound checker checks the mask and command ports after every control write: a single-channel mask write, an unmask-all write, a mask-load write and master clear. It also checks that the command byte holds across every other cycle and that a mode write leaves cascade_o matching bits [7:6]. Behaviours that depend on hidden state can only be shown by the bench's access sequences at the ports: the byte-select toggle and its reset, count decrement and wrap, auto-reload from the base copies, and the read-to-clear status with a same-cycle flag set.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int NCH    = 4;
    localparam int CH_W   = $clog2(NCH);
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int OFF_W  = 4;

    // Control port offsets (upper half of the port space)
    localparam logic [OFF_W-1:0] OFF_CMDSTAT = 4'd8;
    localparam logic [OFF_W-1:0] OFF_SMASK   = 4'd10;
    localparam logic [OFF_W-1:0] OFF_MODE    = 4'd11;
    localparam logic [OFF_W-1:0] OFF_PTRCLR  = 4'd12;
    localparam logic [OFF_W-1:0] OFF_MCLR    = 4'd13;
    localparam logic [OFF_W-1:0] OFF_UNMASK  = 4'd14;
    localparam logic [OFF_W-1:0] OFF_MASKLD  = 4'd15;

    // Working view of one channel
    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] cnt;
    } chan_view_t;

    // Decoded port access
    typedef struct packed {
        logic chan_port;
        logic [CH_W-1:0] chan;
        logic is_cnt;
    } port_sel_t;

    function automatic logic mode_reload(logic [BYTE_W-1:0] d);
        return d[4];
    endfunction

    function automatic logic mode_cascade(logic [BYTE_W-1:0] d);
        return d[7:6] == 2'b11;
    endfunction

    function automatic logic [BYTE_W-1:0] pick_byte(logic [WORD_W-1:0] w, logic hi);
        return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/dma_chan.sv
module dma_chan
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              hi_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_we,
    input  logic              step,
    output chan_view_t        view,
    output logic              reload_en,
    output logic              cascade,
    output logic              tc_hit
);

    chan_view_t base_q, cur_q;
    logic       at_zero;

    assign at_zero = (cur_q.cnt == '0);
    assign tc_hit  = step && at_zero && !wr_cnt;
    assign view    = cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            cur_q     <= '0;
            reload_en <= 1'b0;
            cascade   <= 1'b0;
        end else begin
            if (mode_we) begin
                reload_en <= mode_reload(wdata);
                cascade   <= mode_cascade(wdata);
            end
            // Transfer step; host writes below take precedence
            if (step) begin
                if (!at_zero) begin
                    cur_q.cnt <= cur_q.cnt - 1'b1;
                end else if (reload_en) begin
                    cur_q <= base_q;
                end else begin
                    cur_q.cnt <= '1;
                end
            end
            if (wr_addr) begin
                if (hi_sel) begin
                    base_q.addr[WORD_W-1:BYTE_W] <= wdata;
                    cur_q.addr[WORD_W-1:BYTE_W]  <= wdata;
                end else begin
                    base_q.addr[BYTE_W-1:0] <= wdata;
                    cur_q.addr[BYTE_W-1:0]  <= wdata;
                end
            end
            if (wr_cnt) begin
                if (hi_sel) begin
                    base_q.cnt[WORD_W-1:BYTE_W] <= wdata;
                    cur_q.cnt[WORD_W-1:BYTE_W]  <= wdata;
                end else begin
                    base_q.cnt[BYTE_W-1:0] <= wdata;
                    cur_q.cnt[BYTE_W-1:0]  <= wdata;
                end
            end
        end
    end

endmodule

// File: rtl/dma_ctl.sv
module dma_ctl
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ptr_toggle,
    input  logic              ptr_clr,
    input  logic              mclr,
    input  logic              cmd_we,
    input  logic              smask_we,
    input  logic              unmask_all,
    input  logic              mask_ld,
    input  logic              stat_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NCH-1:0]    tc_hit,
    output logic              byte_hi,
    output logic [NCH-1:0]    mask,
    output logic [NCH-1:0]    tc_flags,
    output logic [BYTE_W-1:0] cmd
);

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            byte_hi  <= 1'b0;
            mask     <= '1;
            tc_flags <= '0;
            cmd      <= '0;
        end else begin
            if (ptr_clr)         byte_hi <= 1'b0;
            else if (ptr_toggle) byte_hi <= !byte_hi;

            if (cmd_we) cmd <= wdata;

            if (unmask_all)   mask <= '0;
            else if (mask_ld) mask <= wdata[NCH-1:0];
            else if (smask_we) mask[wdata[CH_W-1:0]] <= wdata[2];

            // New flags win over the clear-on-read
            tc_flags <= (stat_rd ? '0 : tc_flags) | tc_hit;
        end
    end

endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OFF_W-1:0]  io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    input  logic              xfer_strobe,
    input  logic [CH_W-1:0]   xfer_chan,
    output logic [NCH-1:0]    mask_o,
    output logic [NCH-1:0]    cascade_o,
    output logic [BYTE_W-1:0] cmd_o
);

    port_sel_t      sel;
    logic           byte_hi;
    logic [NCH-1:0] tc_hit, tc_flags, mask;
    chan_view_t     views [NCH];

    assign sel.chan_port = !io_addr[OFF_W-1];
    assign sel.chan      = io_addr[CH_W:1];
    assign sel.is_cnt    = io_addr[0];

    dma_ctl u_ctl (
        .clk        (clk),
        .rst        (rst),
        .ptr_toggle (sel.chan_port && (io_wr || io_rd)),
        .ptr_clr    (io_wr && io_addr == OFF_PTRCLR),
        .mclr       (io_wr && io_addr == OFF_MCLR),
        .cmd_we     (io_wr && io_addr == OFF_CMDSTAT),
        .smask_we   (io_wr && io_addr == OFF_SMASK),
        .unmask_all (io_wr && io_addr == OFF_UNMASK),
        .mask_ld    (io_wr && io_addr == OFF_MASKLD),
        .stat_rd    (io_rd && io_addr == OFF_CMDSTAT),
        .wdata      (io_wdata),
        .tc_hit     (tc_hit),
        .byte_hi    (byte_hi),
        .mask       (mask),
        .tc_flags   (tc_flags),
        .cmd        (cmd_o)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit_me;
        logic unused_reload;
        assign hit_me = io_wr && sel.chan_port && (sel.chan == CH_W'(i));

        dma_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .wr_addr   (hit_me && !sel.is_cnt),
            .wr_cnt    (hit_me && sel.is_cnt),
            .hi_sel    (byte_hi),
            .wdata     (io_wdata),
            .mode_we   (io_wr && io_addr == OFF_MODE && io_wdata[CH_W-1:0] == CH_W'(i)),
            .step      (xfer_strobe && xfer_chan == CH_W'(i) && !mask[i]),
            .view      (views[i]),
            .reload_en (unused_reload),
            .cascade   (cascade_o[i]),
            .tc_hit    (tc_hit[i])
        );
    end

    assign mask_o = mask;

    always_comb begin
        io_rdata = '0;
        if (sel.chan_port) begin
            io_rdata = pick_byte(sel.is_cnt ? views[sel.chan].cnt : views[sel.chan].addr, byte_hi);
        end else if (io_addr == OFF_CMDSTAT) begin
            io_rdata = {{(BYTE_W-NCH){1'b0}}, tc_flags};
        end
    end

endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
    import dma_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OFF_W-1:0]  io_addr,
    input logic              io_wr,
    input logic [BYTE_W-1:0] io_wdata,
    input logic [NCH-1:0]    mask_o,
    input logic [NCH-1:0]    cascade_o,
    input logic [BYTE_W-1:0] cmd_o
);

    AST_SMASK_BIT: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == OFF_SMASK) |=> mask_o[$past(io_wdata[1:0])] == $past(io_wdata[2])); // R4

    AST_UNMASK_ALL: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == OFF_UNMASK) |=> mask_o == '0); // R5

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == OFF_MASKLD) |=> mask_o == $past(io_wdata[3:0])); // R5

    AST_MCLR_MASK: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == OFF_MCLR) |=> (mask_o == '1 && cmd_o == '0)); // R10

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(io_wr && (io_addr == OFF_CMDSTAT || io_addr == OFF_MCLR)) |=> $stable(cmd_o)); // R10

    AST_CASCADE_SET: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == OFF_MODE) |=>
            cascade_o[$past(io_wdata[1:0])] == ($past(io_wdata[7:6]) == 2'b11)); // R6

endmodule

bind dma_regfile dma_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .mask_o    (mask_o),
    .cascade_o (cascade_o),
    .cmd_o     (cmd_o)
);

// File: tb/sim_dma_regfile.sv
module sim_dma_regfile;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] io_addr = '0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       xfer_strobe = 1'b0;
    logic [1:0] xfer_chan = '0;
    logic [3:0] mask_o, cascade_o;
    logic [7:0] cmd_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = !clk;

    dma_regfile u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .xfer_strobe(xfer_strobe),
        .xfer_chan(xfer_chan), .mask_o(mask_o), .cascade_o(cascade_o), .cmd_o(cmd_o)
    );

    // {read, offset, data}: for reads, data is the expected value
    localparam int NV = 22;
    localparam logic [12:0] VEC [NV] = '{
        {1'b0, 4'd12, 8'h00},
        {1'b0, 4'd2,  8'h34}, {1'b0, 4'd2, 8'h12},
        {1'b1, 4'd2,  8'h34}, {1'b1, 4'd2, 8'h12},
        {1'b0, 4'd3,  8'h02}, {1'b0, 4'd3, 8'h00},
        {1'b1, 4'd3,  8'h02}, {1'b1, 4'd3, 8'h00},
        {1'b0, 4'd2,  8'hAB}, {1'b0, 4'd12, 8'h5A},
        {1'b0, 4'd2,  8'hCD}, {1'b0, 4'd12, 8'hFF},
        {1'b1, 4'd2,  8'hCD}, {1'b1, 4'd2, 8'h12},
        {1'b0, 4'd0,  8'h55}, {1'b0, 4'd0, 8'h66},
        {1'b1, 4'd1,  8'h00}, {1'b1, 4'd1, 8'h00},
        {1'b0, 4'd7,  8'hFF}, {1'b0, 4'd7, 8'hFF},
        {1'b1, 4'd7,  8'hFF}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic [3:0] a, input logic [7:0] d,
                          output logic [7:0] q);
        @(negedge clk);
        io_addr = a; io_rd = rd; io_wr = !rd; io_wdata = d;
        #1 q = io_rdata;
        @(posedge clk);
        #1 io_rd = 1'b0; io_wr = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] q;
        access(1'b0, a, d, q);
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] q;
        access(1'b1, a, 8'h00, q);
        chk(req, {8'h00, q}, {8'h00, exp});
    endtask

    task automatic strobe(input logic [1:0] ch);
        @(negedge clk);
        xfer_strobe = 1'b1; xfer_chan = ch;
        @(posedge clk);
        #1 xfer_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        chk("R1 mask", {12'h0, mask_o}, 16'h000F);
        chk("R1 cascade", {12'h0, cascade_o}, 16'h0000);
        chk("R1 cmd", {8'h0, cmd_o}, 16'h0000);
        rd_chk("R1 status", 4'd8, 8'h00);
        rd_chk("R1 count lo", 4'd5, 8'h00);

        // R2/R3 table walk
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][12], VEC[i][11:8], VEC[i][7:0], q);
            if (VEC[i][12]) chk("R2/R3 table", {8'h00, q}, {8'h00, VEC[i][7:0]});
        end
        rd_chk("R2 ch3 count hi", 4'd7, 8'hFF);

        // R4 single-channel mask
        wr(4'd10, 8'h01);
        chk("R4 unmask ch1", {12'h0, mask_o}, 16'h000D);
        wr(4'd10, 8'h05);
        chk("R4 mask ch1", {12'h0, mask_o}, 16'h000F);

        // R5 unmask all and mask load
        wr(4'd14, 8'hFF);
        chk("R5 unmask all", {12'h0, mask_o}, 16'h0000);
        wr(4'd15, 8'hA5);
        chk("R5 mask load", {12'h0, mask_o}, 16'h0005);

        // R6 mode writes
        wr(4'd11, 8'hC2);
        chk("R6 cascade ch2", {12'h0, cascade_o}, 16'h0004);
        wr(4'd11, 8'h12);
        chk("R6 reload ch2 no cascade", {12'h0, cascade_o}, 16'h0000);

        // R7 decrement and masked strobe
        wr(4'd14, 8'h00);
        wr(4'd10, 8'h04);
        strobe(2'd1);
        wr(4'd12, 8'h00);
        rd_chk("R7 ch1 count lo", 4'd3, 8'h01);
        rd_chk("R7 ch1 count hi", 4'd3, 8'h00);
        strobe(2'd0);
        rd_chk("R7 masked ch0 count lo", 4'd1, 8'h00);
        rd_chk("R7 masked ch0 count hi", 4'd1, 8'h00);
        rd_chk("R7 masked no flag", 4'd8, 8'h00);

        // R8 wrap without reload, R9 read-to-clear
        strobe(2'd1);
        strobe(2'd1);
        rd_chk("R8 R9 tc ch1", 4'd8, 8'h02);
        rd_chk("R9 cleared", 4'd8, 8'h00);
        rd_chk("R8 wrap lo", 4'd3, 8'hFF);
        rd_chk("R8 wrap hi", 4'd3, 8'hFF);

        // R8/R12 auto-reload from base copy
        wr(4'd5, 8'h01); wr(4'd5, 8'h00);
        strobe(2'd2);
        strobe(2'd2);
        rd_chk("R8 tc ch2", 4'd8, 8'h04);
        rd_chk("R12 reload lo", 4'd5, 8'h01);
        rd_chk("R12 reload hi", 4'd5, 8'h00);

        // R9 flag set in the same cycle as the status read
        wr(4'd7, 8'h00); wr(4'd7, 8'h00);
        @(negedge clk);
        io_addr = 4'd8; io_rd = 1'b1; xfer_strobe = 1'b1; xfer_chan = 2'd3;
        #1 chk("R9 same-cycle old value", {8'h0, io_rdata}, 16'h0000);
        @(posedge clk);
        #1 io_rd = 1'b0; xfer_strobe = 1'b0;
        rd_chk("R9 same-cycle flag kept", 4'd8, 8'h08);

        // R10 command byte and master clear
        wr(4'd8, 8'h5A);
        chk("R10 cmd load", {8'h0, cmd_o}, 16'h005A);
        strobe(2'd2);
        strobe(2'd2);
        wr(4'd12, 8'h00);
        wr(4'd2, 8'h77);
        wr(4'd13, 8'h00);
        chk("R10 mask set", {12'h0, mask_o}, 16'h000F);
        chk("R10 cmd cleared", {8'h0, cmd_o}, 16'h0000);
        rd_chk("R10 flags cleared", 4'd8, 8'h00);
        wr(4'd2, 8'h88);
        wr(4'd12, 8'h00);
        rd_chk("R10 ptr low after clear", 4'd2, 8'h88);
        rd_chk("R10 address kept", 4'd2, 8'h12);
        rd_chk("R10 reload count kept", 4'd5, 8'h01);

        // R11 temporary register
        rd_chk("R11 temp", 4'd13, 8'h00);

        finish_run();
    end

endmodule